// File: doc/BRIEF.md
# External Agent Read Responder

This block sits on the external-agent side of a multiplexed processor system bus. It watches the processor's valid-out strobe, decodes single-word reads, block reads and writes, and owns a small word-addressed memory array that answers those requests. A write starts with one header cycle that carries the start address. Data beats follow, and the last beat is tagged end-of-data. Each beat lands at the next word address.

A read is answered only after the processor has handed the bus over with its release signal. The first word appears a fixed number of cycles after the request strobe. Later words follow a per-cycle stall mask, and a cleared bit in the mask inserts an idle cycle with valid-in low. While a request is held, the ready outputs toward the processor are withdrawn. The block can also place a null external request on the bus when it is idle and the bus has been released.

Top module: `ext_agent_responder`

## Requirements
- R1: After reset, `agent_valid_o` is 0, `agent_cmd_o` is 3'b000 (idle), and `rd_rdy_o` and `wr_rdy_o` are both 1.
- R2: A request is accepted only while the block is idle. From the cycle after acceptance until the request is finished, `rd_rdy_o` and `wr_rdy_o` are 0. They return to 1 once the block is idle again.
- R3: A write header (valid with command 3'b011, word address in the low address bits) is followed by data beats with command 3'b100, ending with a beat with command 3'b101. Each beat is stored at the next word address, modulo the memory depth.
- R4: With release held high, the first read data word is valid `LATENCY` (default 4) cycles after the cycle in which the request strobe is high.
- R5: A block read (command 3'b010) returns `BLK_BEATS` (default 4) words from consecutive addresses. Each word is issued in a cycle where the stall mask bit is set; the default mask gives data, data, idle, idle, data, data. Every beat but the last carries command 3'b001, and the last carries 3'b010.
- R6: A single read (command 3'b001) returns exactly one word, tagged 3'b010.
- R7: `agent_valid_o` is high only in a cycle that follows a cycle with `proc_release_i` high. While release is low, the response and its stall-mask position are held.
- R8: A `null_req_i` pulse while the block is idle, release is high and no processor strobe is present drives one cycle of `agent_valid_o` with command 3'b111. With release low, the pulse is dropped.
- R9: Processor strobes that arrive while a read is pending or being returned leave the memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| proc_valid_i | input | 1 | Processor valid-out strobe |
| proc_cmd_i | input | 3 | Processor command code |
| proc_ad_i | input | DATA_W | Processor address or write data |
| proc_release_i | input | 1 | Processor has released the bus |
| null_req_i | input | 1 | Request to issue a null external request |
| agent_valid_o | output | 1 | Responder valid-in strobe |
| agent_cmd_o | output | 3 | Responder command code |
| agent_ad_o | output | DATA_W | Read data toward the processor |
| rd_rdy_o | output | 1 | Responder can accept a read |
| wr_rdy_o | output | 1 | Responder can accept a write |

## Verification
The bench uses the default parameters: a 16-word array of 32-bit words, latency 4, four-beat blocks and the six-cycle mask 110011. With these values a single block write that starts at address 14 wraps the array. The four-beat read shows both the gap in the middle of the pattern and the end-of-data tag within one short window. A six-cycle mask is not a power of two, so the pattern position takes the explicit wrap branch. A late release moves the first beat past the nominal latency, which shows that the mask position is held.

// File: rtl/ear_pkg.sv
package ear_pkg;
    typedef enum logic [2:0] {
        PC_NONE  = 3'd0,
        PC_RD_ONE = 3'd1,
        PC_RD_BLK = 3'd2,
        PC_WR    = 3'd3,
        PC_WDATA = 3'd4,
        PC_WEOD  = 3'd5
    } pcmd_e;

    typedef enum logic [2:0] {
        AC_IDLE = 3'd0,
        AC_DATA = 3'd1,
        AC_EOD  = 3'd2,
        AC_NULL = 3'd7
    } acmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RESP,
        ST_WRITE
    } st_e;
endpackage

// File: rtl/ear_mem.sv
module ear_mem #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/ear_stall_mask.sv
module ear_stall_mask #(
    parameter int PAT_LEN = 6,
    parameter logic [PAT_LEN-1:0] MASK = 6'b110011,
    localparam int PW = (PAT_LEN > 1) ? $clog2(PAT_LEN) : 1
) (
    input  logic [PW-1:0] pos,
    output logic          slot,
    output logic [PW-1:0] pos_nxt
);
    assign slot = MASK[pos];

    generate
        if ((1 << PW) == PAT_LEN) begin : g_pow2
            assign pos_nxt = pos + PW'(1);
        end else begin : g_wrap
            assign pos_nxt = (pos == PW'(PAT_LEN - 1)) ? '0 : pos + PW'(1);
        end
    endgenerate
endmodule

// File: rtl/ext_agent_responder.sv
module ext_agent_responder #(
    parameter int DATA_W    = 32,
    parameter int DEPTH     = 16,
    parameter int LATENCY   = 4,
    parameter int BLK_BEATS = 4,
    parameter int PAT_LEN   = 6,
    parameter logic [PAT_LEN-1:0] STALL_MASK = 6'b110011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              proc_valid_i,
    input  logic [2:0]        proc_cmd_i,
    input  logic [DATA_W-1:0] proc_ad_i,
    input  logic              proc_release_i,
    input  logic              null_req_i,
    output logic              agent_valid_o,
    output logic [2:0]        agent_cmd_o,
    output logic [DATA_W-1:0] agent_ad_o,
    output logic              rd_rdy_o,
    output logic              wr_rdy_o
);
    import ear_pkg::*;

    localparam int AW        = $clog2(DEPTH);
    localparam int PW        = (PAT_LEN > 1) ? $clog2(PAT_LEN) : 1;
    localparam int BW        = $clog2(BLK_BEATS) + 1;
    localparam int WAIT_INIT = LATENCY - 3;
    localparam int CW        = (LATENCY > 2) ? $clog2(LATENCY) : 1;

    typedef struct packed {
        st_e               st;
        logic [AW-1:0]     addr;
        logic [BW-1:0]     left;
        logic [PW-1:0]     pos;
        logic [CW-1:0]     cnt;
        logic              vld;
        logic [2:0]        cmd;
        logic [DATA_W-1:0] dat;
    } state_t;

    state_t r_q, r_d;

    logic              we;
    logic [DATA_W-1:0] rd_word;
    logic              slot;
    logic [PW-1:0]     pos_nxt;

    ear_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) mem_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .waddr (r_q.addr),
        .wdata (proc_ad_i),
        .raddr (r_q.addr),
        .rdata (rd_word)
    );

    ear_stall_mask #(.PAT_LEN(PAT_LEN), .MASK(STALL_MASK)) mask_i (
        .pos     (r_q.pos),
        .slot    (slot),
        .pos_nxt (pos_nxt)
    );

    always_comb begin
        r_d     = r_q;
        r_d.vld = 1'b0;
        r_d.cmd = AC_IDLE;
        r_d.dat = '0;
        we      = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (proc_valid_i) begin
                    if (proc_cmd_i == PC_RD_ONE || proc_cmd_i == PC_RD_BLK) begin
                        r_d.st   = ST_WAIT;
                        r_d.addr = proc_ad_i[AW-1:0];
                        r_d.cnt  = CW'(WAIT_INIT);
                        r_d.left = (proc_cmd_i == PC_RD_BLK) ? BW'(BLK_BEATS) : BW'(1);
                    end else if (proc_cmd_i == PC_WR) begin
                        r_d.st   = ST_WRITE;
                        r_d.addr = proc_ad_i[AW-1:0];
                    end
                end else if (null_req_i && proc_release_i) begin
                    r_d.vld = 1'b1;
                    r_d.cmd = AC_NULL;
                end
            end
            ST_WAIT: begin
                if (r_q.cnt == '0) begin
                    r_d.st  = ST_RESP;
                    r_d.pos = '0;
                end else begin
                    r_d.cnt = r_q.cnt - CW'(1);
                end
            end
            ST_RESP: begin
                if (proc_release_i) begin
                    r_d.pos = pos_nxt;
                    if (slot) begin
                        r_d.vld  = 1'b1;
                        r_d.dat  = rd_word;
                        r_d.cmd  = (r_q.left == BW'(1)) ? AC_EOD : AC_DATA;
                        r_d.addr = r_q.addr + AW'(1);
                        r_d.left = r_q.left - BW'(1);
                        if (r_q.left == BW'(1)) r_d.st = ST_IDLE;
                    end
                end
            end
            ST_WRITE: begin
                if (proc_valid_i && (proc_cmd_i == PC_WDATA || proc_cmd_i == PC_WEOD)) begin
                    we       = 1'b1;
                    r_d.addr = r_q.addr + AW'(1);
                    if (proc_cmd_i == PC_WEOD) r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.st  <= ST_IDLE;
            r_q.cmd <= AC_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign agent_valid_o = r_q.vld;
    assign agent_cmd_o   = r_q.cmd;
    assign agent_ad_o    = r_q.dat;
    assign rd_rdy_o      = (r_q.st == ST_IDLE);
    assign wr_rdy_o      = (r_q.st == ST_IDLE);

    // R7
    release_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        agent_valid_o |-> $past(proc_release_i));

    // R2
    rdy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_valid_i && rd_rdy_o && (proc_cmd_i == PC_RD_ONE || proc_cmd_i == PC_RD_BLK))
        |=> !rd_rdy_o);

    // R5
    eod_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (agent_valid_o && agent_cmd_o == AC_EOD) |=> (agent_cmd_o != AC_DATA));

    // R8
    null_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (agent_valid_o && agent_cmd_o == AC_NULL) |-> $past(null_req_i));

    // R5
    strobe_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        agent_valid_o == (agent_cmd_o != AC_IDLE));
endmodule

// File: tb/ext_agent_responder_tb_top.sv
`timescale 1ns/1ps
module ext_agent_responder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pv = 1'b0;
    logic [2:0]  pcmd = 3'd0;
    logic [31:0] pad = '0;
    logic        rel = 1'b1;
    logic        nreq = 1'b0;
    logic        avld;
    logic [2:0]  acmd;
    logic [31:0] aad;
    logic        rrdy, wrdy;

    int total = 0;
    int bad = 0;
    logic [31:0] shadow [16];

    always #4 clk = ~clk;

    ext_agent_responder dut_i (
        .clk(clk), .rst_n(rst_n), .proc_valid_i(pv), .proc_cmd_i(pcmd),
        .proc_ad_i(pad), .proc_release_i(rel), .null_req_i(nreq),
        .agent_valid_o(avld), .agent_cmd_o(acmd), .agent_ad_o(aad),
        .rd_rdy_o(rrdy), .wr_rdy_o(wrdy)
    );

    // each entry: {block flag, word address}; release comes up at cycle [9:5] (0 = always high)
    localparam logic [9:0] RD_TAB [0:6] = '{
        {5'd0, 1'b1, 4'd0}, {5'd0, 1'b0, 4'd5}, {5'd0, 1'b1, 4'd13},
        {5'd0, 1'b1, 4'd14}, {5'd5, 1'b1, 4'd2}, {5'd6, 1'b0, 4'd9},
        {5'd2, 1'b1, 4'd7}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input int addr, input int n, input logic [31:0] base);
        @(negedge clk);
        pv = 1'b1; pcmd = 3'd3; pad = 32'(addr);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == 0) chk(wrdy == 1'b0 && rrdy == 1'b0, "R2 write busy", {30'd0, wrdy, rrdy}, 32'd0);
            pcmd = (i == n - 1) ? 3'd5 : 3'd4;
            pad  = base + 32'(i) * 32'h0101;
            shadow[(addr + i) % 16] = pad;
        end
        @(negedge clk);
        pv = 1'b0; pcmd = 3'd0;
        chk(wrdy == 1'b1 && avld == 1'b0, "R3 write done idle", {31'd0, wrdy}, 32'd1);
    endtask

    task automatic do_read(input int addr, input bit blk, input int rel_on, input bit inject);
        int f;
        int beat;
        int nb;
        bit expv;
        f = (rel_on + 1 > 4) ? rel_on + 1 : 4;
        nb = blk ? 4 : 1;
        beat = 0;
        @(negedge clk);
        pv = 1'b1; pcmd = blk ? 3'd2 : 3'd1; pad = 32'(addr);
        if (rel_on > 0) rel = 1'b0;
        for (int k = 1; k <= 16; k++) begin
            @(negedge clk);
            pv = 1'b0; pcmd = 3'd0;
            expv = (k == f) || (blk && (k == f + 1 || k == f + 4 || k == f + 5));
            if (blk) chk(avld == expv, "R5 block pattern", {31'd0, avld}, {31'd0, expv});
            else     chk(avld == expv, "R6 single beat", {31'd0, avld}, {31'd0, expv});
            if (k == f) chk(avld == 1'b1, "R4 latency", {31'd0, avld}, 32'd1);
            if (rel_on > 3 && k <= rel_on) chk(avld == 1'b0, "R7 no data before release", {31'd0, avld}, 32'd0);
            if (expv && avld) begin
                chk(aad == shadow[(addr + beat) % 16], "R5 data word", aad, shadow[(addr + beat) % 16]);
                chk(acmd == ((beat == nb - 1) ? 3'd2 : 3'd1), "R5 beat tag", {29'd0, acmd},
                    (beat == nb - 1) ? 32'd2 : 32'd1);
                beat++;
            end
            if (k == 2) chk(rrdy == 1'b0, "R2 read busy", {31'd0, rrdy}, 32'd0);
            if (k == rel_on) rel = 1'b1;
            if (inject && k == 2) begin pv = 1'b1; pcmd = 3'd3; pad = 32'(addr); end
            if (inject && k == 3) begin pv = 1'b1; pcmd = 3'd5; pad = 32'hDEAD_BEEF; end
        end
        chk(rrdy == 1'b1 && wrdy == 1'b1, "R2 ready again", {30'd0, wrdy, rrdy}, 32'd3);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(avld == 1'b0 && acmd == 3'd0, "R1 reset outputs", {28'd0, acmd, avld}, 32'd0);
        chk(rrdy == 1'b1 && wrdy == 1'b1, "R1 reset ready", {30'd0, wrdy, rrdy}, 32'd3);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 fill, including a wrapping burst
        do_write(0, 14, 32'hA500_0000);
        do_write(14, 4, 32'h5A00_0100);

        for (int t = 0; t < 7; t++) begin
            do_read(int'(RD_TAB[t][3:0]), RD_TAB[t][4], int'(RD_TAB[t][9:5]), 1'b0);
        end

        // R9 strobes during a read change nothing
        do_read(3, 1'b1, 0, 1'b1);
        do_read(3, 1'b0, 0, 1'b0);
        do_read(4, 1'b0, 0, 1'b0);

        // R8 null request when released
        @(negedge clk);
        nreq = 1'b1;
        @(negedge clk);
        nreq = 1'b0;
        chk(avld == 1'b1 && acmd == 3'd7, "R8 null issued", {28'd0, acmd, avld}, 32'hF);
        @(negedge clk);
        chk(avld == 1'b0, "R8 null one cycle", {31'd0, avld}, 32'd0);

        // R8 dropped with release low
        rel = 1'b0; nreq = 1'b1;
        @(negedge clk);
        nreq = 1'b0;
        chk(avld == 1'b0, "R8 null dropped", {31'd0, avld}, 32'd0);
        @(negedge clk);
        chk(avld == 1'b0, "R8 null dropped later", {31'd0, avld}, 32'd0);
        rel = 1'b1;
        repeat (2) @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule